// File: doc/BRIEF.md
# Cursor Colour Stack Register

This block stores the two colours a hardware cursor is painted with: a foreground colour and a background colour, each 24 bits. Software reaches them through an indexed control-register port. One bus access selects a 7-bit index and a second access moves a byte through the data port. Both colours sit at their own indices. They are loaded three bytes per colour, lowest byte first, and a single byte pointer chooses which lane each data write lands in. The two colours share that pointer.

The pointer moves forward by one after every colour write and returns to 0 after the top byte. Software brings it back to the start by reading the data port while a dedicated "rewind" index is selected. Other indices land in a plain byte-wide store, so the port behaves like an ordinary bank of control registers. The renderer reads both colours as parallel 24-bit outputs with no handshake. Read data is registered and is held until the next read.

Top module: `cursor_color_regs`

## Requirements
- R1: A write with `bus_sel`=0 loads the index register with `bus_wdata[6:0]` and drops bit 7. A read with `bus_sel`=0 returns `{1'b0, index}`.
- R2: A data write (`bus_sel`=1) while the index is 0x4A writes `bus_wdata` into one lane of `fg_color`. Pointer 0 selects bits 7:0, pointer 1 selects bits 15:8 and pointer 2 selects bits 23:16. The other two lanes and `bg_color` keep their values.
- R3: A data write while the index is 0x4B writes the lane of `bg_color` that the pointer selects, using the same lane mapping. `fg_color` keeps its value.
- R4: Each colour write advances the pointer by one, and the step after 2 gives 0. The pointer never holds 3.
- R5: Foreground and background writes step the same pointer, so a write to one colour moves the lane used by the next write to the other.
- R6: A data read while the index is 0x45 sets the pointer to 0 and returns the generic store byte at 0x45.
- R7: A data read while the index is 0x4A or 0x4B returns the byte of that colour in the lane the pointer selects. The pointer does not move.
- R8: Data writes at any index other than 0x4A and 0x4B go to a byte store and can be read back. They leave both colours and the pointer unchanged.
- R9: Reset clears the index, the pointer, both colours, the store and the read data.
- R10: `bus_rdata` updates on the clock edge that samples a read and then holds its value through any cycles that carry no read, including cycles with writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | 0 selects the index register, 1 selects the data port |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| fg_color | output | 24 | Foreground cursor colour |
| bg_color | output | 24 | Background cursor colour |

## Verification
The checks assume that a bus master never raises the read and write strobes in the same cycle, since that cycle would have two meanings for the pointer. The stimulus applies exactly one strobe per access and a check flags any overlap. The checks also assume that strobes change only away from the rising edge. The stimulus drives every input at the falling edge and holds each strobe for exactly one cycle.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int IDX_W     = 7;
  localparam int BYTE_W    = 8;
  localparam int COL_BYTES = 3;
  localparam int COL_W     = BYTE_W * COL_BYTES;
  localparam int PTR_W     = $clog2(COL_BYTES);

  localparam logic [IDX_W-1:0] IDX_FG     = 7'h4A;
  localparam logic [IDX_W-1:0] IDX_BG     = 7'h4B;
  localparam logic [IDX_W-1:0] IDX_REWIND = 7'h45;

  typedef struct packed {
    logic idx_wr;
    logic idx_rd;
    logic fg_wr;
    logic bg_wr;
    logic st_wr;
    logic col_rd;
    logic st_rd;
    logic ptr_clr;
    logic sel_bg;
  } ccr_acc_t;
endpackage

// File: rtl/ccr_rst_sync.sv
module ccr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ccr_decode.sv
module ccr_decode
  import ccr_pkg::*;
(
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [IDX_W-1:0] idx,
  output ccr_acc_t         acc
);
  logic hit_fg, hit_bg, hit_rw;

  always_comb begin
    hit_fg      = (idx == IDX_FG);
    hit_bg      = (idx == IDX_BG);
    hit_rw      = (idx == IDX_REWIND);
    acc         = '0;
    acc.idx_wr  = bus_wr && !bus_sel;
    acc.idx_rd  = bus_rd && !bus_sel;
    acc.fg_wr   = bus_wr && bus_sel && hit_fg;
    acc.bg_wr   = bus_wr && bus_sel && hit_bg;
    acc.st_wr   = bus_wr && bus_sel && !hit_fg && !hit_bg;
    acc.col_rd  = bus_rd && bus_sel && (hit_fg || hit_bg);
    acc.st_rd   = bus_rd && bus_sel && !hit_fg && !hit_bg;
    acc.ptr_clr = bus_rd && bus_sel && hit_rw;
    acc.sel_bg  = hit_bg;
  end
endmodule

// File: rtl/ccr_byte_ptr.sv
module ccr_byte_ptr #(
  parameter int LANES = 3,
  localparam int PW   = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          clr,
  output logic [PW-1:0] ptr
);
  logic [PW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = adv || clr;
    if (clr)                             ptr_d = '0;
    else if (ptr_q == PW'(LANES - 1))    ptr_d = '0;
    else                                 ptr_d = ptr_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/ccr_color_reg.sv
module ccr_color_reg #(
  parameter int LANES  = 3,
  parameter int LANE_W = 8,
  localparam int PW    = $clog2(LANES),
  localparam int W     = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PW-1:0]     lane,
  input  logic [LANE_W-1:0] wdata,
  output logic [W-1:0]      color
);
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic              en;
    logic [LANE_W-1:0] q;

    always_comb en = we && (lane == PW'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end

    assign color[b*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/ccr_store.sv
module ccr_store #(
  parameter int AW = 7,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic en;
    always_comb en = we && (addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[i] <= '0;
      else if (en) mem_q[i] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/cursor_color_regs.sv
module cursor_color_regs
  import ccr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [COL_W-1:0]  fg_color,
  output logic [COL_W-1:0]  bg_color
);
  logic              rst_sync_n;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_en;
  logic [PTR_W-1:0]  ptr_q;
  ccr_acc_t          acc;
  logic [BYTE_W-1:0] st_rdata;
  logic [BYTE_W-1:0] col_byte;
  logic [COL_W-1:0]  col_sel;
  logic [BYTE_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;

  ccr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ccr_decode u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .idx     (idx_q),
    .acc     (acc)
  );

  always_comb begin
    idx_en = acc.idx_wr;
    idx_d  = bus_wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  idx_q <= '0;
    else if (idx_en)  idx_q <= idx_d;
  end

  ccr_byte_ptr #(.LANES(COL_BYTES)) u_ptr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .adv   (acc.fg_wr || acc.bg_wr),
    .clr   (acc.ptr_clr),
    .ptr   (ptr_q)
  );

  ccr_color_reg #(.LANES(COL_BYTES), .LANE_W(BYTE_W)) u_fg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (acc.fg_wr),
    .lane  (ptr_q),
    .wdata (bus_wdata),
    .color (fg_color)
  );

  ccr_color_reg #(.LANES(COL_BYTES), .LANE_W(BYTE_W)) u_bg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (acc.bg_wr),
    .lane  (ptr_q),
    .wdata (bus_wdata),
    .color (bg_color)
  );

  ccr_store #(.AW(IDX_W), .DW(BYTE_W)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (acc.st_wr),
    .addr  (idx_q),
    .wdata (bus_wdata),
    .rdata (st_rdata)
  );

  always_comb begin
    col_sel  = acc.sel_bg ? bg_color : fg_color;
    col_byte = col_sel[ptr_q*BYTE_W +: BYTE_W];
    rdata_en = acc.idx_rd || acc.col_rd || acc.st_rd;
    if (acc.idx_rd)      rdata_d = BYTE_W'(idx_q);
    else if (acc.col_rd) rdata_d = col_byte;
    else                 rdata_d = st_rdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
  import ccr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [IDX_W-1:0]  idx,
  input logic [PTR_W-1:0]  ptr,
  input logic [COL_W-1:0]  fg,
  input logic [COL_W-1:0]  bg
);
  logic col_wr, oth_wr, rw_rd, plain_rd;
  assign col_wr   = bus_wr && bus_sel && (idx == IDX_FG || idx == IDX_BG);
  assign oth_wr   = bus_wr && bus_sel && !(idx == IDX_FG || idx == IDX_BG);
  assign rw_rd    = bus_rd && bus_sel && (idx == IDX_REWIND);
  assign plain_rd = bus_rd && !(bus_sel && idx == IDX_REWIND);

  p_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  p_idx_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel) |=> idx == $past(bus_wdata[IDX_W-1:0]));

  p_bg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel && idx == IDX_FG) |=> $stable(bg));

  p_fg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel && idx == IDX_BG) |=> $stable(fg));

  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < PTR_W'(COL_BYTES));

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    col_wr |=> ptr == (($past(ptr) == PTR_W'(COL_BYTES - 1)) ? '0 : $past(ptr) + PTR_W'(1)));

  p_ptr_rewind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rw_rd |=> ptr == '0);

  p_ptr_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    plain_rd |=> $stable(ptr));

  p_other_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oth_wr |=> ($stable(ptr) && $stable(fg) && $stable(bg)));
endmodule

bind cursor_color_regs ccr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .idx       (idx_q),
  .ptr       (ptr_q),
  .fg        (fg_color),
  .bg        (bg_color)
);

// File: tb/tb_cursor_color_regs.sv
module tb_cursor_color_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 31;

  localparam logic [1:0] OP_IW = 2'd0;
  localparam logic [1:0] OP_DW = 2'd1;
  localparam logic [1:0] OP_DR = 2'd2;
  localparam logic [1:0] OP_IR = 2'd3;

  // {op, data_or_expected, requirement number}
  localparam logic [13:0] VEC [NVEC] = '{
    {OP_IW, 8'h4A, 4'd0},
    {OP_DR, 8'h00, 4'd9},   // R9 foreground starts at zero
    {OP_DW, 8'h11, 4'd0},
    {OP_DW, 8'h22, 4'd0},
    {OP_DW, 8'h33, 4'd0},
    {OP_DR, 8'h11, 4'd4},   // R4 wrapped to lane 0
    {OP_DR, 8'h11, 4'd7},   // R7 read did not move pointer
    {OP_IW, 8'hCB, 4'd0},
    {OP_IR, 8'h4B, 4'd1},   // R1 bit 7 dropped
    {OP_DW, 8'hA1, 4'd0},
    {OP_IW, 8'h4A, 4'd0},
    {OP_DW, 8'h44, 4'd0},
    {OP_DR, 8'h33, 4'd5},   // R5 shared pointer now at lane 2
    {OP_IW, 8'h4B, 4'd0},
    {OP_DW, 8'hB3, 4'd0},
    {OP_DR, 8'hA1, 4'd4},   // R4 wrap after lane 2
    {OP_DW, 8'hC1, 4'd0},
    {OP_IW, 8'h45, 4'd0},
    {OP_DR, 8'h00, 4'd6},   // R6 rewind read returns store byte
    {OP_IW, 8'h4B, 4'd0},
    {OP_DR, 8'hC1, 4'd6},   // R6 pointer back at lane 0
    {OP_IW, 8'h10, 4'd0},
    {OP_DW, 8'h5A, 4'd0},
    {OP_DR, 8'h5A, 4'd8},   // R8 store read back
    {OP_IW, 8'h4B, 4'd0},
    {OP_DR, 8'hC1, 4'd8},   // R8 store write left pointer
    {OP_IW, 8'h45, 4'd0},
    {OP_DW, 8'h77, 4'd0},
    {OP_DR, 8'h77, 4'd8},   // R8 store at rewind index
    {OP_IW, 8'h4A, 4'd0},
    {OP_DR, 8'h11, 4'd6}    // R6 foreground lane 0
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [23:0] fg_color, bg_color;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  cursor_color_regs dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .fg_color  (fg_color),
    .bg_color  (bg_color)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_op(input logic [1:0] op, input logic [7:0] d, input int req);
    bus_sel   = (op != OP_IW) && (op != OP_IR);
    bus_wr    = (op == OP_IW) || (op == OP_DW);
    bus_rd    = (op == OP_DR) || (op == OP_IR);
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    if (op == OP_DR || op == OP_IR) check(req, {16'h0, bus_rdata}, {16'h0, d});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(9, fg_color, 24'h0);              // R9
    check(9, bg_color, 24'h0);              // R9
    check(9, {16'h0, bus_rdata}, 24'h0);    // R9

    for (int i = 0; i < NVEC; i++)
      do_op(VEC[i][13:12], VEC[i][11:4], int'(VEC[i][3:0]));

    check(2, fg_color, 24'h334411);         // R2 lanes and untouched lanes
    check(3, bg_color, 24'hB300C1);         // R3

    // R10: read data holds across write-only cycles
    do_op(OP_IW, 8'h10, 0);
    do_op(OP_DW, 8'h99, 0);
    check(10, {16'h0, bus_rdata}, 24'h000011);  // R10
    do_op(OP_DR, 8'h99, 10);                    // R10 updates on a read

    // R9: reset in mid-run
    rst_n = 1'b0;
    #1;
    check(9, fg_color, 24'h0);
    check(9, bg_color, 24'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_op(OP_IR, 8'h00, 9);                 // R9 index cleared
    do_op(OP_IW, 8'h10, 0);
    do_op(OP_DR, 8'h00, 9);                 // R9 store cleared
    do_op(OP_IW, 8'h4B, 0);
    do_op(OP_DW, 8'hEE, 0);
    check(9, bg_color, 24'h0000EE);         // R9 pointer back at lane 0

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule